// File: doc/BRIEF.md
# Keyed Flash Command Front End

This block sits between a 32-bit register bus and a flash array command port. Software places a target byte address in an address register and then writes a data register to launch one flash operation. The block forwards that operation as a one-cycle command carrying the address, the half-word to program, and an erase flag. It then holds a busy flag for a programmable number of clock cycles, with separate counts for programming and for erasing.

Flash operations are guarded by a key register. Writing 0xA5 arms the key logic. A second write then opens the block: 0xF1 grants exactly one operation, and 0xF2 grants any number of operations until 0x5A closes it again. Any other key value locks the block.

A mode bit in the configuration register chooses the operation. When the bit is clear, the data write programs its low half-word. When the bit is set, the data write erases the 1 KiB page that contains the address, and the data value is ignored. A data write that the block cannot accept sets a sticky error bit instead of issuing a command.

Top module: `keyed_flash_ctl`

## Requirements
- R1: After reset, the configuration register reads 0, the key register reads 0 (locked), and no command is issued.
- R2: The configuration register is reachable at three bus offsets. Offset 0x00 reads it and writes its erase-mode bit (bit 18) directly. Offset 0x04 sets the written ones and offset 0x08 clears them. All three offsets read the same value.
- R3: The key register is at offset 0x28, and bits [1:0] of a read return the key state: 0 locked, 1 armed, 2 open for one operation, 3 open for many. From any state except armed, a key write of 0xA5 arms the block. From armed, 0xF1 gives state 2 and 0xF2 gives state 3.
- R4: In state 2, the first accepted data write returns the key state to 0.
- R5: In state 3, the key state persists across accepted operations until a key write of 0x5A returns it to 0.
- R6: Any key write outside the sequence returns the key state to 0. This covers a value other than 0xF1 or 0xF2 while armed, and any value other than 0xA5 in another state.
- R7: With the erase-mode bit clear, an accepted write to the data register (offset 0x24) issues a command with the erase flag low. The command address is the value held in the address register (offset 0x20), and the command data is the low 16 bits of the written value.
- R8: With the erase-mode bit set, an accepted data write issues a command with the erase flag high. The command address is the held address with its low 10 bits cleared, and the command data is 0 whatever value was written.
- R9: Bit 20 of the configuration register reads 1 for exactly PROG_CYCLES cycles after an accepted program and ERASE_CYCLES cycles after an accepted erase, starting from the cycle after the data write.
- R10: Some data writes are rejected: those made while locked or armed, those made while busy, and program writes to an odd address. A rejected write issues no command and sets the error bit (bit 3).
- R11: The error bit is cleared only by writing a 1 to bit 3 at offset 0x08. Writes at offsets 0x00 and 0x04 leave it unchanged.
- R12: The command strobe is high for exactly one cycle, in the cycle after the accepted data write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | BUS_AW | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one register write per cycle |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| fl_go | output | 1 | One-cycle command strobe to the flash array |
| fl_erase | output | 1 | Command is a page erase (1) or a half-word program (0) |
| fl_addr | output | FLASH_AW | Command byte address |
| fl_data | output | 16 | Half-word to program |

## Verification
The assertions rely on the bus carrying at most one register write per cycle. They also rely on both cycle counts being at least 1, so that an accepted operation always produces a busy window that blocks the next data write for at least one cycle. The stimulus issues one write per task call with an idle cycle between writes. It uses busy counts of 5 and 12, and it waits for the busy flag to drop before it launches the next operation it expects to be accepted.

// File: rtl/kfc_pkg.sv
// Package: shared types and register map constants for the keyed flash front end.
// Assumes a byte-addressed register bus.
package kfc_pkg;
    typedef enum logic [1:0] {
        KS_LOCKED = 2'd0,
        KS_ARMED  = 2'd1,
        KS_SINGLE = 2'd2,
        KS_MULTI  = 2'd3
    } key_state_t;

    // Register byte offsets. The three configuration aliases sit 4 bytes apart.
    localparam int OFF_CFG_ALL = 'h00;
    localparam int OFF_CFG_SET = 'h04;
    localparam int OFF_CFG_CLR = 'h08;
    localparam int OFF_WADDR   = 'h20;
    localparam int OFF_WDATA   = 'h24;
    localparam int OFF_KEY     = 'h28;

    // Configuration bit positions.
    localparam int CFG_ERR_BIT   = 3;
    localparam int CFG_ERASE_BIT = 18;
    localparam int CFG_BUSY_BIT  = 20;

    // Key codes.
    localparam logic [7:0] KEY_ARM   = 8'hA5;
    localparam logic [7:0] KEY_ONCE  = 8'hF1;
    localparam logic [7:0] KEY_MANY  = 8'hF2;
    localparam logic [7:0] KEY_CLOSE = 8'h5A;
endpackage

// File: rtl/kfc_key_seq.sv
// Module: key sequencer. It tracks the two-write unlock and relocks after a
// one-shot operation. Assumes key_we and op_start are never high in the same cycle.
module kfc_key_seq
    import kfc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_we,
    input  logic [7:0] key_val,
    input  logic       op_start,
    output key_state_t state
);
    // State update on key writes and on consumption of a one-shot grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= KS_LOCKED;
        end else if (key_we) begin
            if (state == KS_ARMED) begin
                if (key_val == KEY_ONCE)      state <= KS_SINGLE;
                else if (key_val == KEY_MANY) state <= KS_MULTI;
                else                          state <= KS_LOCKED;
            end else begin
                state <= (key_val == KEY_ARM) ? KS_ARMED : KS_LOCKED;
            end
        end else if (op_start && state == KS_SINGLE) begin
            state <= KS_LOCKED;
        end
    end
endmodule

// File: rtl/kfc_busy_timer.sv
// Module: busy timer. It holds busy for a per-operation cycle count after a start.
// Assumes start only arrives while idle and both counts are at least 1.
module kfc_busy_timer #(
    parameter int PROG_CYCLES  = 8,
    parameter int ERASE_CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic is_erase,
    output logic busy
);
    localparam int MAXC = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;

    // Load on start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (start)      cnt <= is_erase ? CW'(ERASE_CYCLES) : CW'(PROG_CYCLES);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    // Busy whenever the count is non-zero.
    always_comb busy = (cnt != '0);
endmodule

// File: rtl/kfc_cfg_reg.sv
// Module: configuration register holding the erase-mode bit and the sticky
// error bit, written through three aliases. Assumes one-hot alias strobes.
module kfc_cfg_reg
    import kfc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_all,
    input  logic        wr_set,
    input  logic        wr_clr,
    input  logic [31:0] wdata,
    input  logic        reject,
    output logic        erase_en,
    output logic        err
);
    // Erase-mode bit: direct, set-alias and clear-alias writes.
    always_ff @(posedge clk) begin
        if (!rst_n)      erase_en <= 1'b0;
        else if (wr_all) erase_en <= wdata[CFG_ERASE_BIT];
        else if (wr_set) erase_en <= erase_en | wdata[CFG_ERASE_BIT];
        else if (wr_clr) erase_en <= erase_en & ~wdata[CFG_ERASE_BIT];
    end

    // Sticky error: set by a rejected data write, cleared only through the clear alias.
    always_ff @(posedge clk) begin
        if (!rst_n)                          err <= 1'b0;
        else if (reject)                     err <= 1'b1;
        else if (wr_clr && wdata[CFG_ERR_BIT]) err <= 1'b0;
    end
endmodule

// File: rtl/keyed_flash_ctl.sv
// Module: keyed flash front end top. It decodes the register bus, gates data
// writes on the key state and busy flag, and issues registered commands to the
// flash array. Assumes at most one bus write per cycle and a PAGE_BYTES power of two.
module keyed_flash_ctl
    import kfc_pkg::*;
#(
    parameter int FLASH_AW     = 18,
    parameter int BUS_AW       = 6,
    parameter int PAGE_BYTES   = 1024,
    parameter int PROG_CYCLES  = 8,
    parameter int ERASE_CYCLES = 40
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BUS_AW-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    input  logic                bus_we,
    output logic [31:0]         bus_rdata,
    output logic                fl_go,
    output logic                fl_erase,
    output logic [FLASH_AW-1:0] fl_addr,
    output logic [15:0]         fl_data
);
    localparam logic [BUS_AW-1:0]   A_ALL   = BUS_AW'(OFF_CFG_ALL);
    localparam logic [BUS_AW-1:0]   A_SET   = BUS_AW'(OFF_CFG_SET);
    localparam logic [BUS_AW-1:0]   A_CLR   = BUS_AW'(OFF_CFG_CLR);
    localparam logic [BUS_AW-1:0]   A_WADDR = BUS_AW'(OFF_WADDR);
    localparam logic [BUS_AW-1:0]   A_WDATA = BUS_AW'(OFF_WDATA);
    localparam logic [BUS_AW-1:0]   A_KEY   = BUS_AW'(OFF_KEY);
    localparam logic [FLASH_AW-1:0] PAGE_MASK = FLASH_AW'(PAGE_BYTES - 1);

    logic hit_all, hit_set, hit_clr, hit_waddr, hit_data, hit_key;
    logic unlocked, aligned, accept, reject;
    logic erase_en, err_flag, busy;
    logic [FLASH_AW-1:0] waddr;
    key_state_t key_state;

    // Address decode of bus writes.
    always_comb begin
        hit_all   = bus_we && (bus_addr == A_ALL);
        hit_set   = bus_we && (bus_addr == A_SET);
        hit_clr   = bus_we && (bus_addr == A_CLR);
        hit_waddr = bus_we && (bus_addr == A_WADDR);
        hit_data  = bus_we && (bus_addr == A_WDATA);
        hit_key   = bus_we && (bus_addr == A_KEY);
    end

    // Acceptance of a data write.
    always_comb begin
        unlocked = (key_state == KS_SINGLE) || (key_state == KS_MULTI);
        aligned  = erase_en || !waddr[0];
        accept   = hit_data && unlocked && !busy && aligned;
        reject   = hit_data && !accept;
    end

    kfc_key_seq u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_we   (hit_key),
        .key_val  (bus_wdata[7:0]),
        .op_start (accept),
        .state    (key_state)
    );

    kfc_busy_timer #(
        .PROG_CYCLES  (PROG_CYCLES),
        .ERASE_CYCLES (ERASE_CYCLES)
    ) u_busy (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .is_erase (erase_en),
        .busy     (busy)
    );

    kfc_cfg_reg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_all   (hit_all),
        .wr_set   (hit_set),
        .wr_clr   (hit_clr),
        .wdata    (bus_wdata),
        .reject   (reject),
        .erase_en (erase_en),
        .err      (err_flag)
    );

    // Target address register.
    always_ff @(posedge clk) begin
        if (!rst_n)         waddr <= '0;
        else if (hit_waddr) waddr <= bus_wdata[FLASH_AW-1:0];
    end

    // Command strobe, one cycle per accepted operation.
    always_ff @(posedge clk) begin
        if (!rst_n) fl_go <= 1'b0;
        else        fl_go <= accept;
    end

    // Command payload, captured on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fl_erase <= 1'b0;
            fl_addr  <= '0;
            fl_data  <= '0;
        end else if (accept) begin
            fl_erase <= erase_en;
            fl_addr  <= erase_en ? (waddr & ~PAGE_MASK) : waddr;
            fl_data  <= erase_en ? 16'h0000 : bus_wdata[15:0];
        end
    end

    // Read mux.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_ALL, A_SET, A_CLR: begin
                bus_rdata[CFG_ERR_BIT]   = err_flag;
                bus_rdata[CFG_ERASE_BIT] = erase_en;
                bus_rdata[CFG_BUSY_BIT]  = busy;
            end
            A_WADDR: bus_rdata[FLASH_AW-1:0] = waddr;
            A_KEY:   bus_rdata[1:0] = key_state;
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/kfc_checker.sv
// Module: property checker for the keyed flash front end, bound to the top.
// Assumes both busy counts are at least 1.
module kfc_checker
    import kfc_pkg::*;
#(
    parameter int FLASH_AW   = 18,
    parameter int PAGE_BYTES = 1024
) (
    input logic                clk,
    input logic                rst_n,
    input logic                fl_go,
    input logic                fl_erase,
    input logic [FLASH_AW-1:0] fl_addr,
    input logic                busy,
    input key_state_t          key_state,
    input logic                err,
    input logic                data_wr
);
    localparam logic [FLASH_AW-1:0] PAGE_MASK = FLASH_AW'(PAGE_BYTES - 1);

    a_r9_busy_with_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        fl_go |-> busy);

    a_r8_page_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_go && fl_erase) |-> ((fl_addr & PAGE_MASK) == '0));

    a_r7_halfword_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_go && !fl_erase) |-> !fl_addr[0]);

    a_r4_single_consumed: assert property (@(posedge clk) disable iff (!rst_n)
        fl_go |-> (key_state != KS_SINGLE));

    a_r10_err_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(data_wr));

    a_r12_one_cycle_go: assert property (@(posedge clk) disable iff (!rst_n)
        fl_go |=> !fl_go);
endmodule

bind keyed_flash_ctl kfc_checker #(
    .FLASH_AW   (FLASH_AW),
    .PAGE_BYTES (PAGE_BYTES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fl_go     (fl_go),
    .fl_erase  (fl_erase),
    .fl_addr   (fl_addr),
    .busy      (busy),
    .key_state (key_state),
    .err       (err_flag),
    .data_wr   (hit_data)
);

// File: tb/keyed_flash_ctl_tb.sv
`timescale 1ns/1ps
// Bench: directed scenarios for the keyed flash front end, one task each.
module keyed_flash_ctl_tb;
    localparam int AW = 18;
    localparam int BW = 6;
    localparam int PC = 5;
    localparam int EC = 12;

    localparam logic [BW-1:0] O_ALL = 6'h00, O_SET = 6'h04, O_CLR = 6'h08;
    localparam logic [BW-1:0] O_WA = 6'h20, O_WD = 6'h24, O_KEY = 6'h28;
    localparam logic [31:0] B_ERR = 32'h0000_0008;
    localparam logic [31:0] B_ERASE = 32'h0004_0000;
    localparam logic [31:0] B_BUSY = 32'h0010_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [BW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic fl_go, fl_erase;
    logic [AW-1:0] fl_addr;
    logic [15:0] fl_data;

    int vectors = 0;
    int miscompares = 0;
    int cmd_cnt = 0;
    logic last_erase;
    logic [AW-1:0] last_addr;
    logic [15:0] last_data;

    always #2 clk = ~clk;

    keyed_flash_ctl #(
        .FLASH_AW(AW), .BUS_AW(BW), .PAGE_BYTES(1024),
        .PROG_CYCLES(PC), .ERASE_CYCLES(EC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .fl_go(fl_go), .fl_erase(fl_erase),
        .fl_addr(fl_addr), .fl_data(fl_data)
    );

    // Command monitor, sampling just after each rising edge.
    always @(posedge clk) begin
        #1;
        if (fl_go) begin
            cmd_cnt++;
            last_erase = fl_erase;
            last_addr  = fl_addr;
            last_data  = fl_data;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [BW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [BW-1:0] a, output logic [31:0] d);
        bus_addr = a; bus_we = 1'b0;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic busy_len(output int n);
        logic [31:0] v;
        n = 0;
        for (int i = 0; i < 1000; i++) begin
            rd(O_ALL, v);
            if ((v & B_BUSY) == 0) break;
            n++;
            @(negedge clk);
        end
    endtask

    task automatic key_seq(input logic [7:0] second);
        wr(O_KEY, 32'hA5);
        wr(O_KEY, {24'h0, second});
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(O_ALL, v);  chk("R1 cfg after reset", v, 32'h0);
        rd(O_KEY, v);  chk("R1 key after reset", v, 32'h0);
        chk("R1 no command", cmd_cnt, 0);
    endtask

    task automatic t_aliases_and_err;
        logic [31:0] v;
        wr(O_SET, B_ERASE);
        rd(O_ALL, v); chk("R2 set alias", v, B_ERASE);
        rd(O_CLR, v); chk("R2 read via clear alias", v, B_ERASE);
        wr(O_CLR, B_ERASE);
        rd(O_ALL, v); chk("R2 clear alias", v, 32'h0);
        wr(O_ALL, B_ERASE);
        rd(O_SET, v); chk("R2 base write", v, B_ERASE);
        wr(O_ALL, 32'h0);
        wr(O_WD, 32'h1111);
        rd(O_ALL, v); chk("R10 locked write sets err", v, B_ERR);
        chk("R10 locked write no command", cmd_cnt, 0);
        wr(O_ALL, 32'h0);
        wr(O_SET, B_ERR);
        rd(O_ALL, v); chk("R11 err kept by base and set alias", v, B_ERR);
        wr(O_CLR, B_ERR);
        rd(O_ALL, v); chk("R11 err cleared by clear alias", v, 32'h0);
    endtask

    task automatic t_single_program;
        logic [31:0] v;
        int n;
        int c0;
        c0 = cmd_cnt;
        wr(O_KEY, 32'hA5);
        rd(O_KEY, v); chk("R3 armed state", v, 32'd1);
        wr(O_KEY, 32'hF1);
        rd(O_KEY, v); chk("R3 single state", v, 32'd2);
        wr(O_WA, 32'h100);
        wr(O_WD, 32'h1234ABCD);
        chk("R12 one command pulse", cmd_cnt, c0 + 1);
        chk("R7 program flag", last_erase, 0);
        chk("R7 program addr", last_addr, 18'h100);
        chk("R7 program data", last_data, 16'hABCD);
        rd(O_KEY, v); chk("R4 relock after one op", v, 32'd0);
        busy_len(n); chk("R9 program busy cycles", n, PC);
        wr(O_WD, 32'h5555);
        chk("R4 second write no command", cmd_cnt, c0 + 1);
        rd(O_ALL, v); chk("R10 err after relock", v, B_ERR);
        wr(O_CLR, B_ERR);
    endtask

    task automatic t_multi;
        logic [31:0] v;
        int n;
        int c0;
        c0 = cmd_cnt;
        key_seq(8'hF2);
        rd(O_KEY, v); chk("R3 multi state", v, 32'd3);
        wr(O_WA, 32'h2FE);
        wr(O_WD, 32'h0000BEEF);
        wr(O_WD, 32'h0000DEAD);
        chk("R10 busy write no command", cmd_cnt, c0 + 1);
        rd(O_ALL, v); chk("R10 busy write err", v & B_ERR, B_ERR);
        wr(O_CLR, B_ERR);
        busy_len(n);
        wr(O_WA, 32'h300);
        wr(O_WD, 32'h00007777);
        chk("R5 second op accepted", cmd_cnt, c0 + 2);
        chk("R7 second data", last_data, 16'h7777);
        rd(O_KEY, v); chk("R5 still open", v, 32'd3);
        busy_len(n);
        wr(O_WA, 32'h301);
        wr(O_WD, 32'h1);
        chk("R10 odd program no command", cmd_cnt, c0 + 2);
        rd(O_ALL, v); chk("R10 odd program err", v, B_ERR);
        wr(O_CLR, B_ERR);
        wr(O_KEY, 32'h5A);
        rd(O_KEY, v); chk("R5 close key", v, 32'd0);
    endtask

    task automatic t_erase;
        logic [31:0] v;
        int n;
        int c0;
        c0 = cmd_cnt;
        wr(O_SET, B_ERASE);
        key_seq(8'hF2);
        wr(O_WA, 32'h237B);
        wr(O_WD, 32'hFFFF1234);
        chk("R8 erase issued", cmd_cnt, c0 + 1);
        chk("R8 erase flag", last_erase, 1);
        chk("R8 page aligned addr", last_addr, 18'h2000);
        chk("R8 data ignored", last_data, 16'h0);
        busy_len(n); chk("R9 erase busy cycles", n, EC);
        wr(O_KEY, 32'h5A);
        wr(O_CLR, B_ERASE);
        rd(O_ALL, v); chk("R2 erase mode cleared", v, 32'h0);
    endtask

    task automatic t_broken_keys;
        logic [31:0] v;
        key_seq(8'h33);
        rd(O_KEY, v); chk("R6 bad second key", v, 32'd0);
        wr(O_KEY, 32'hF1);
        rd(O_KEY, v); chk("R6 unlock without arm", v, 32'd0);
        key_seq(8'hA5);
        rd(O_KEY, v); chk("R6 double arm", v, 32'd0);
        key_seq(8'hF2);
        wr(O_KEY, 32'h77);
        rd(O_KEY, v); chk("R6 stray key while open", v, 32'd0);
    endtask

    initial begin
        #(4 * 150000);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_aliases_and_err;
        t_single_program;
        t_multi;
        t_erase;
        t_broken_keys;
        repeat (3) @(negedge clk);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule